// File: doc/BRIEF.md
# LIN Sync-Field Baud Rate Measurer

This block finds the bit rate of a LIN bus by timing the sync byte that follows a break. Once armed by a start request (issued by break detection elsewhere), it watches the synchronised receive line on the system clock. The first falling edge, at the start bit, starts a free-running span counter. The falling edge at the start of the last data bit of the 0x55 sync byte stops it. That span is eight bit periods long.

A divider value with 4 fractional bits (one sixteenth resolution) is the span count divided by 8 and rounded. Since one bit lasts 16 times the divider in clock cycles, the span is 128 times the divider. The result is accepted only if it lies between a minimum supplied at an input and a maximum fixed by the nominal divider divided by 0.85, which allows a 15% slower bus. An accepted value replaces the output divider. A rejected value, or a measurement that never sees its stop edge before the counter saturates, raises an error strobe and keeps the previous divider.

Top module: `lin_sync_meter`

## Requirements
- R1: After reset the divider output equals the nominal value NOM_DIV16 (default 400, i.e. 25.0 in units of 1/16), and the done and error strobes are 0.
- R2: Falling edges on the receive line while no measurement is armed produce no done strobe and leave the divider unchanged.
- R3: After a start request, the first falling edge of the receive line opens the window. The fourth falling edge after it closes the window. The measured count N is the number of clock cycles between these two edges, which is eight bit periods for a 0x55 byte sent least significant bit first.
- R4: The candidate divider is (N + 4) >> 3: the count divided by 8, rounded half up, with the low 4 bits as the fraction. When accepted, it appears on the divider output in the same cycle as the done strobe.
- R5: A candidate below the minimum divider input gives done together with error, and the divider output keeps its previous value.
- R6: A candidate above MAX_DIV16 = floor(NOM_DIV16*100/85) (470 by default) gives done together with error, and the divider output keeps its previous value.
- R7: If the span counter reaches its all-ones value (2^CNT_W - 1, 16383 by default) before the closing edge, the measurement aborts with done and error, and the divider output is kept.
- R8: Done is a single-cycle strobe, and error is only ever 1 in a cycle where done is 1.
- R9: A start request during an open window discards the partial measurement and re-arms, so the next falling edge opens a fresh window.
- R10: Candidates equal to the minimum or to MAX_DIV16 are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arms (or re-arms) a measurement |
| rx_i | input | 1 | Synchronised receive line, idle high |
| min_div_i | input | CNT_W-2 | Smallest acceptable divider, 4 fractional bits |
| div_o | output | CNT_W-2 | Baud divider, 4 fractional bits |
| done_o | output | 1 | One-cycle strobe at the end of a measurement |
| err_o | output | 1 | Out-of-range or overflow, valid with done_o |

## Verification
The bench places span counts on both sides of a rounding step (remainders 3 and 4 after division by 8). A design that truncates, or that counts from the wrong edge, returns a divider off by one sixteenth. It drives sync bytes whose results sit exactly on the minimum and maximum and one step outside each. A design with an off-by-one limit comparison would either reject a legal rate or overwrite the divider with an illegal one. It also holds the line low after the opening edge until the counter saturates, and it sends a restart in mid-window followed by a full byte. A design that lets the counter wrap, or that keeps counting edges across the restart, would report a bogus divider or no strobe at all.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_MEAS = 2'd2
    } meas_state_e;

endpackage

// File: rtl/lin_fall_detect.sv
module lin_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic fall_o
);
    logic rx_d, rx_q;

    always_comb begin
        rx_d   = rx_i;
        fall_o = rx_q & ~rx_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx_d;
    end
endmodule

// File: rtl/lin_span_counter.sv
module lin_span_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = CNT_W'(1);
        else if (en_i && (cnt_q != CNT_MAX))
            cnt_d = cnt_q + CNT_W'(1);
        cnt_o = cnt_q;
        sat_o = (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/lin_div_convert.sv
module lin_div_convert #(
    parameter int CNT_W     = 14,
    parameter int DIV16_W   = 12,
    parameter int MAX_DIV16 = 470
) (
    input  logic [CNT_W-1:0]   span_i,
    input  logic [DIV16_W-1:0] min_i,
    output logic [DIV16_W-1:0] div_o,
    output logic               ok_o
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [DIV16_W-1:0] MAX_V = DIV16_W'(MAX_DIV16);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = {1'b0, span_i} + SUM_W'(4);
        div_o = DIV16_W'(sum >> 3);
        ok_o  = (div_o >= min_i) && (div_o <= MAX_V);
    end
endmodule

// File: rtl/lin_sync_meter.sv
module lin_sync_meter #(
    parameter int CNT_W     = 14,
    parameter int NOM_DIV16 = 400,
    parameter int SPAN_BITS = 8,
    localparam int DIV16_W  = CNT_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rx_i,
    input  logic [DIV16_W-1:0] min_div_i,
    output logic [DIV16_W-1:0] div_o,
    output logic               done_o,
    output logic               err_o
);
    import lin_sync_pkg::*;

    localparam int MAX_DIV16  = (NOM_DIV16 * 100) / 85;
    localparam int STOP_FALLS = SPAN_BITS / 2;
    localparam int FALL_W     = $clog2(STOP_FALLS + 1);

    typedef struct packed {
        meas_state_e        state;
        logic [FALL_W-1:0]  falls;
        logic [DIV16_W-1:0] div;
        logic               done;
        logic               err;
    } meter_regs_t;

    meter_regs_t r_d, r_q;

    logic               fall;
    logic               cnt_clr, cnt_en, cnt_sat;
    logic [CNT_W-1:0]   span;
    logic [DIV16_W-1:0] cand;
    logic               cand_ok;

    lin_fall_detect i_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .fall_o (fall)
    );

    lin_span_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .en_i  (cnt_en),
        .cnt_o (span),
        .sat_o (cnt_sat)
    );

    lin_div_convert #(
        .CNT_W     (CNT_W),
        .DIV16_W   (DIV16_W),
        .MAX_DIV16 (MAX_DIV16)
    ) i_conv (
        .span_i (span),
        .min_i  (min_div_i),
        .div_o  (cand),
        .ok_o   (cand_ok)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        cnt_clr  = 1'b0;
        cnt_en   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) r_d.state = ST_ARM;
            end
            ST_ARM: begin
                if (fall) begin
                    r_d.state = ST_MEAS;
                    r_d.falls = '0;
                    cnt_clr   = 1'b1;
                end
            end
            ST_MEAS: begin
                cnt_en = 1'b1;
                if (start_i) begin
                    r_d.state = ST_ARM;
                end else if (fall && r_q.falls == FALL_W'(STOP_FALLS - 1)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    if (cand_ok) r_d.div = cand;
                    else         r_d.err = 1'b1;
                end else if (cnt_sat) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b1;
                end else if (fall) begin
                    r_d.falls = r_q.falls + FALL_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.falls <= '0;
            r_q.div   <= DIV16_W'(NOM_DIV16);
            r_q.done  <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign div_o  = r_q.div;
    assign done_o = r_q.done;
    assign err_o  = r_q.err;

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5 R6 R7
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o || err_o) |-> $stable(div_o));

    // R10
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (div_o >= min_div_i && div_o <= DIV16_W'(MAX_DIV16)));
endmodule

// File: tb/test_lin_sync_meter.sv
module test_lin_sync_meter;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 12;
    localparam int NOM        = 400;
    localparam int MAXV       = (NOM * 100) / 85;
    localparam int MINV       = 340;

    typedef struct {
        int    div;
        bit    err;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          rx_i = 1'b1;
    logic [DW-1:0] min_div_i = DW'(MINV);
    logic [DW-1:0] div_o;
    logic          done_o, err_o;

    exp_t sb_q[$];
    int   total = 0;
    int   bad = 0;
    int   cur_div = NOM;
    int   done_cnt = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_sync_meter i_lin_sync_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rx_i      (rx_i),
        .min_div_i (min_div_i),
        .div_o     (div_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    task automatic chk(string req, bit ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    // expected result of a window of n cycles
    task automatic expect_span(string req, int n);
        exp_t e;
        int   c;
        c     = (n + 4) >> 3;
        e.req = req;
        if (c >= MINV && c <= MAXV) begin
            e.div = c; e.err = 1'b0; cur_div = c;
        end else begin
            e.div = cur_div; e.err = 1'b1;
        end
        sb_q.push_back(e);
    endtask

    // drives a 0x55 byte, LSB first; window = 8*bl + extra
    task automatic send_sync(string req, int bl, int extra, bit do_arm);
        if (do_arm) arm();
        cyc(20);
        expect_span(req, 8 * bl + extra);
        rx_i = 1'b0; cyc(bl);          // start bit
        for (int b = 0; b < 7; b++) begin
            rx_i = (b % 2 == 0);
            cyc((b == 6) ? bl + extra : bl);
        end
        rx_i = 1'b0; cyc(bl);          // bit 7, closing edge
        rx_i = 1'b1; cyc(bl);          // stop bit
        cyc(10);
        chk({req, " div after frame"}, div_o == DW'(cur_div), int'(div_o), cur_div);
    endtask

    // monitor: pops the scoreboard whenever a result appears
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_o) begin
                done_cnt++;
                if (sb_q.size() == 0) begin
                    chk("R2 unexpected done", 1'b0, 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk({e.req, " div"}, div_o == DW'(e.div), int'(div_o), e.div);
                    chk({e.req, " err"}, err_o == e.err, int'(err_o), int'(e.err));
                end
            end
            if (err_o && !done_o) chk("R8 err without done", 1'b0, 1, 0);
            if (prev_done && done_o) chk("R8 done longer than one cycle", 1'b0, 1, 0);
            prev_done = done_o;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk("watchdog", 1'b0, 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        // R1
        chk("R1 reset div", div_o == DW'(NOM), int'(div_o), NOM);
        chk("R1 reset done", done_o == 1'b0, int'(done_o), 0);
        chk("R1 reset err", err_o == 1'b0, int'(err_o), 0);

        // R2: edges without arming
        for (int i = 0; i < 6; i++) begin
            rx_i = 1'b0; cyc(50);
            rx_i = 1'b1; cyc(50);
        end
        cyc(10);
        chk("R2 div unchanged", div_o == DW'(NOM), int'(div_o), NOM);
        chk("R2 no done", done_cnt == 0, done_cnt, 0);

        send_sync("R3 nominal", 400, 0, 1'b1);
        send_sync("R4 remainder 3", 410, 3, 1'b1);
        send_sync("R4 remainder 4", 410, 4, 1'b1);
        send_sync("R5 below min", 300, 0, 1'b1);
        send_sync("R6 above max", 500, 0, 1'b1);
        send_sync("R10 at min", 340, 0, 1'b1);
        send_sync("R10 at max", 470, 0, 1'b1);
        send_sync("R6 one over max", 470, 4, 1'b1);
        send_sync("R5 one under min", 339, 3, 1'b1);

        // R7: no closing edge, counter saturates
        arm();
        cyc(20);
        sb_q.push_back('{div: cur_div, err: 1'b1, req: "R7 overflow"});
        rx_i = 1'b0;
        cyc(16500);
        rx_i = 1'b1;
        cyc(20);
        chk("R7 div kept", div_o == DW'(cur_div), int'(div_o), cur_div);

        // R9: restart in mid-window
        arm();
        cyc(10);
        rx_i = 1'b0; cyc(200);
        rx_i = 1'b1; cyc(200);
        rx_i = 1'b0; cyc(200);
        rx_i = 1'b1; cyc(100);
        arm();
        send_sync("R9 restart", 420, 0, 1'b0);

        cyc(20);
        chk("scoreboard drained", sb_q.size() == 0, sb_q.size(), 0);
        chk("R8 done count", done_cnt == 11, done_cnt, 11);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule